// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether a 1-, 2- or 4-byte I/O access at a 16-bit port number is allowed by the current task's deny bitmap. It keeps two pieces of state: the byte address of the bitmap and a bitmap limit counted in bytes. Both are reloaded whenever a task register load or a task switch presents the new task segment's base, limit, kind (32-bit or 16-bit) and the I/O map base that was taken from the word at byte offset 102 of a 32-bit segment. Only a 32-bit segment whose map base is nonzero and lies below the segment limit gets a usable bitmap. Every other configuration sets the limit to zero.

A check starts with a one-cycle `chk_start` carrying the port and length. If the bitmap limit is zero, or if the byte index (port + length)/8 reaches the limit, the block reports a fault without touching memory. Otherwise it issues exactly one 16-bit read at bitmap address + port/8. It builds a mask of `length` ones shifted left by port mod 8. A set bitmap bit under the mask denies the access. The word read lets an access that straddles a byte boundary be judged with a single fetch. The result is given by a one-cycle `chk_done` pulse, with `chk_fault` meaning a general-protection fault whose error code, `chk_err_code`, is zero.

The controller has three states. IDLE waits for a start. IDLE→DONE is taken when the range test fails, and IDLE→READ when it passes. READ holds the read request until `mem_rd_valid` arrives, then goes READ→DONE with the mask test result. DONE raises `chk_done` for one cycle and returns DONE→IDLE.

Top module: `io_perm_check`

## Requirements
- R1: After reset `chk_done` and `mem_rd_req` are low and the bitmap limit is zero, so a check made before any configuration faults without a memory read.
- R2: A configuration with `cfg_is32`=1, a nonzero map base and map base < segment limit sets the limit to (segment limit − map base) and the bitmap address to segment base + map base.
- R3: A configuration with `cfg_is32`=0, with map base zero, or with map base ≥ segment limit sets the bitmap limit to zero.
- R4: The bitmap limit keeps only the low 16 bits of (segment limit − map base).
- R5: When (port + length)/8 ≥ bitmap limit, `chk_done` and `chk_fault` are high in the cycle after the start and no read is issued.
- R6: When the bitmap limit is zero, every check faults in the cycle after the start and no read is issued.
- R7: An in-range check raises `mem_rd_req` in the cycle after the start, with `mem_rd_addr` = bitmap address + port/8. The request and the address are held until `mem_rd_valid`, and exactly one read is made. The word is little-endian: bit k of the word is bit k mod 8 of byte port/8 + k/8.
- R8: The mask is ((1<<length)−1) << (port mod 8) within 16 bits. The check faults if (`mem_rd_data` & mask) ≠ 0 and is permitted otherwise. This includes a mask that crosses into the second byte.
- R9: `chk_done` is high for exactly one cycle, in the cycle after `mem_rd_valid` for a read check. `chk_fault` is meaningful only with it, and `chk_err_code` is zero.
- R10: The only legal lengths are 1, 2 and 4. A length of 4 tests four consecutive port bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Load a new task segment configuration |
| cfg_is32 | input | 1 | 1 = 32-bit task segment, 0 = 16-bit |
| cfg_seg_base | input | 32 | Task segment base address |
| cfg_seg_limit | input | 32 | Task segment limit |
| cfg_map_base | input | 16 | I/O map base from the segment |
| chk_start | input | 1 | Start a check (accepted in IDLE) |
| chk_port | input | 16 | Port number |
| chk_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| mem_rd_req | output | 1 | 16-bit bitmap read request |
| mem_rd_addr | output | 32 | Byte address of the bitmap word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Bitmap word, little-endian |
| chk_done | output | 1 | One-cycle result strobe |
| chk_fault | output | 1 | Access denied (general-protection fault) |
| chk_err_code | output | 16 | Fault error code (always zero) |

## Verification
Checks are run under five configurations: unconfigured, 16-bit segment, zero map base, map base equal to the limit, and a limit that needs truncation. This separates the "no bitmap" rule from the range and mask rules. Inside the valid bitmap, one-byte ports next to a set bit tell whether the mask is shifted correctly. Two-byte accesses at ports 6 and 7 tell whether the second byte of the fetched word is used. Four-byte accesses at ports 123 and 124 sit on either side of the limit comparison and show whether the comparison is ≥ or >. Read latency changes from zero to several cycles, which shows whether the request is held and whether the result waits for the data.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } chk_state_t;

endpackage

// File: rtl/io_perm_cfg.sv
module io_perm_cfg #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_is32,
    input  logic [ADDR_W-1:0] cfg_seg_base,
    input  logic [ADDR_W-1:0] cfg_seg_limit,
    input  logic [LIM_W-1:0]  cfg_map_base,
    output logic [LIM_W-1:0]  bitmap_lim,
    output logic [ADDR_W-1:0] bitmap_addr
);

    logic [ADDR_W-1:0] map_ext;
    logic [ADDR_W-1:0] span;
    logic              usable;

    always_comb begin
        map_ext = ADDR_W'(cfg_map_base);
        span    = cfg_seg_limit - map_ext;
        usable  = cfg_is32 && (cfg_map_base != '0) && (map_ext < cfg_seg_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitmap_lim  <= '0;
            bitmap_addr <= '0;
        end else if (cfg_valid) begin
            if (usable) begin
                bitmap_lim  <= span[LIM_W-1:0];
                bitmap_addr <= cfg_seg_base + map_ext;
            end else begin
                bitmap_lim  <= '0;
            end
        end
    end

endmodule

// File: rtl/io_perm_mask.sv
module io_perm_mask #(
    parameter int PORT_W = 16,
    parameter int WORD_W = 16,
    parameter int LEN_W  = 3,
    parameter int LIM_W  = 16
) (
    input  logic [PORT_W-1:0] port,
    input  logic [LEN_W-1:0]  len,
    input  logic [LIM_W-1:0]  lim,
    output logic [PORT_W-4:0] byte_off,
    output logic [WORD_W-1:0] bit_mask,
    output logic              range_fault
);

    localparam int SUM_W = PORT_W + 1;
    localparam int POS_W = LEN_W + 4;
    localparam int CMP_W = LIM_W + SUM_W;

    logic [SUM_W-1:0] end_port;
    logic [POS_W-1:0] lo_pos;
    logic [POS_W-1:0] hi_pos;

    always_comb begin
        end_port    = SUM_W'(port) + SUM_W'(len);
        byte_off    = port[PORT_W-1:3];
        lo_pos      = POS_W'(port[2:0]);
        hi_pos      = lo_pos + POS_W'(len);
        range_fault = (lim == '0) ||
                      (CMP_W'(end_port[SUM_W-1:3]) >= CMP_W'(lim));
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_mask
        assign bit_mask[b] = (POS_W'(b) >= lo_pos) && (POS_W'(b) < hi_pos);
    end

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
    import io_perm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int WORD_W = 16,
    parameter int LEN_W  = 3,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_is32,
    input  logic [ADDR_W-1:0] cfg_seg_base,
    input  logic [ADDR_W-1:0] cfg_seg_limit,
    input  logic [LIM_W-1:0]  cfg_map_base,
    input  logic              chk_start,
    input  logic [PORT_W-1:0] chk_port,
    input  logic [LEN_W-1:0]  chk_len,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              chk_done,
    output logic              chk_fault,
    output logic [15:0]       chk_err_code
);

    chk_state_t        state;
    chk_state_t        state_nx;
    logic [LIM_W-1:0]  bitmap_lim;
    logic [ADDR_W-1:0] bitmap_addr;
    logic [PORT_W-4:0] byte_off;
    logic [WORD_W-1:0] bit_mask;
    logic              range_fault;
    logic [WORD_W-1:0] mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fault_q;

    io_perm_cfg #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_is32      (cfg_is32),
        .cfg_seg_base  (cfg_seg_base),
        .cfg_seg_limit (cfg_seg_limit),
        .cfg_map_base  (cfg_map_base),
        .bitmap_lim    (bitmap_lim),
        .bitmap_addr   (bitmap_addr)
    );

    io_perm_mask #(.PORT_W(PORT_W), .WORD_W(WORD_W), .LEN_W(LEN_W), .LIM_W(LIM_W)) u_mask (
        .port        (chk_port),
        .len         (chk_len),
        .lim         (bitmap_lim),
        .byte_off    (byte_off),
        .bit_mask    (bit_mask),
        .range_fault (range_fault)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (chk_start) state_nx = range_fault ? ST_DONE : ST_READ;
            ST_READ: if (mem_rd_valid) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && chk_start) begin
                mask_q  <= bit_mask;
                addr_q  <= bitmap_addr + ADDR_W'(byte_off);
                fault_q <= range_fault;
            end else if (state == ST_READ && mem_rd_valid) begin
                fault_q <= |(mem_rd_data & mask_q);
            end
        end
    end

    always_comb begin
        mem_rd_req   = (state == ST_READ);
        mem_rd_addr  = addr_q;
        chk_done     = (state == ST_DONE);
        chk_fault    = chk_done && fault_q;
        chk_err_code = '0;
    end

endmodule

// File: rtl/io_perm_check_sva.sv
module io_perm_check_sva #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter int LEN_W  = 3,
    parameter int LIM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [LIM_W-1:0]  lim,
    input logic              cfg_valid,
    input logic              cfg_is32,
    input logic [ADDR_W-1:0] cfg_seg_limit,
    input logic [LIM_W-1:0]  cfg_map_base,
    input logic              chk_start,
    input logic [PORT_W-1:0] chk_port,
    input logic [LEN_W-1:0]  chk_len,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              chk_done,
    input logic              chk_fault
);

    logic [LIM_W-1:0] span_lo;
    logic [PORT_W:0]  end_port;
    logic             out_of_map;
    logic             map_ok;

    always_comb begin
        span_lo    = cfg_seg_limit[LIM_W-1:0] - cfg_map_base;
        end_port   = {1'b0, chk_port} + (PORT_W + 1)'(chk_len);
        out_of_map = ((PORT_W + 1)'(end_port >> 3) >= (PORT_W + 1)'(lim));
        map_ok     = cfg_is32 && (cfg_map_base != '0) &&
                     (ADDR_W'(cfg_map_base) < cfg_seg_limit);
    end

    assert_cfg_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && map_ok |=> lim == $past(span_lo));

    assert_cfg_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !map_ok |=> lim == '0);

    assert_range_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start && !busy && out_of_map |=> chk_done && chk_fault && !mem_rd_req);

    assert_zero_lim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start && !busy && lim == '0 |=> chk_done && chk_fault);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

    assert_read_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_valid |=> chk_done && !mem_rd_req);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done);

    assert_len_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start && !busy |-> chk_len == 3'd1 || chk_len == 3'd2 || chk_len == 3'd4);

endmodule

bind io_perm_check io_perm_check_sva #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .LEN_W(LEN_W), .LIM_W(LIM_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (state != io_perm_pkg::ST_IDLE),
    .lim           (bitmap_lim),
    .cfg_valid     (cfg_valid),
    .cfg_is32      (cfg_is32),
    .cfg_seg_limit (cfg_seg_limit),
    .cfg_map_base  (cfg_map_base),
    .chk_start     (chk_start),
    .chk_port      (chk_port),
    .chk_len       (chk_len),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_valid  (mem_rd_valid),
    .chk_done      (chk_done),
    .chk_fault     (chk_fault)
);

// File: tb/test_io_perm_check.sv
`timescale 1ns/1ps
module test_io_perm_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_is32 = 1'b0;
    logic [31:0] cfg_seg_base = '0;
    logic [31:0] cfg_seg_limit = '0;
    logic [15:0] cfg_map_base = '0;
    logic        chk_start = 1'b0;
    logic [15:0] chk_port = '0;
    logic [2:0]  chk_len = 3'd1;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        chk_done;
    logic        chk_fault;
    logic [15:0] chk_err_code;

    int checks = 0;
    int errors = 0;
    int ref_lim = 0;
    longint ref_addr = 0;
    logic [7:0] bmem [0:255];

    always #2.5 clk = ~clk;

    io_perm_check i_io_perm_check (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_is32(cfg_is32),
        .cfg_seg_base(cfg_seg_base), .cfg_seg_limit(cfg_seg_limit),
        .cfg_map_base(cfg_map_base), .chk_start(chk_start), .chk_port(chk_port),
        .chk_len(chk_len), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .chk_done(chk_done), .chk_fault(chk_fault), .chk_err_code(chk_err_code)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic configure(input bit is32, input longint base, input longint limit,
                             input int mapb);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_is32 = is32;
        cfg_seg_base = 32'(base); cfg_seg_limit = 32'(limit); cfg_map_base = 16'(mapb);
        if (is32 && mapb != 0 && longint'(mapb) < limit) begin
            ref_lim  = int'((limit - mapb) & 64'hFFFF);
            ref_addr = (base + mapb) & 64'hFFFF_FFFF;
        end else begin
            ref_lim = 0;
        end
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic run_check(input string tag, input int port, input int len, input int lat);
        bit rfault;
        int off;
        int mask;
        int word;
        int a;
        @(negedge clk);
        chk_start = 1'b1; chk_port = 16'(port); chk_len = 3'(len);
        rfault = (ref_lim == 0) || (((port + len) / 8) >= ref_lim);
        off  = port / 8;
        mask = (((1 << len) - 1) << (port % 8)) & 16'hFFFF;
        @(negedge clk);
        chk_start = 1'b0;
        if (rfault) begin
            check({tag, " range done"}, longint'(chk_done), 1);
            check({tag, " range fault"}, longint'(chk_fault), 1);
            check({tag, " no read"}, longint'(mem_rd_req), 0);
        end else begin
            check({tag, " req R7"}, longint'(mem_rd_req), 1);
            check({tag, " addr R7"}, longint'(mem_rd_addr), (ref_addr + off) & 64'hFFFF_FFFF);
            check({tag, " early done R9"}, longint'(chk_done), 0);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                check({tag, " req held R7"}, longint'(mem_rd_req), 1);
                check({tag, " wait done R9"}, longint'(chk_done), 0);
            end
            a = int'(mem_rd_addr[7:0]);
            word = {bmem[(a + 1) % 256], bmem[a]};
            mem_rd_valid = 1'b1; mem_rd_data = 16'(word);
            @(negedge clk);
            mem_rd_valid = 1'b0;
            check({tag, " done R9"}, longint'(chk_done), 1);
            check({tag, " mask fault R8"}, longint'(chk_fault), ((word & mask) != 0) ? 1 : 0);
            check({tag, " one read R7"}, longint'(mem_rd_req), 0);
        end
        check({tag, " err code R9"}, longint'(chk_err_code), 0);
        @(negedge clk);
        check({tag, " pulse R9"}, longint'(chk_done), 0);
        check({tag, " idle req"}, longint'(mem_rd_req), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        bmem[8'h41] = 8'h01;
        bmem[8'h42] = 8'h04;
        bmem[8'h50] = 8'hFF;
        bmem[8'h4F] = 8'h81;

        repeat (3) @(negedge clk);
        check("R1 reset done", longint'(chk_done), 0);
        check("R1 reset req", longint'(mem_rd_req), 0);
        rst_n = 1'b1;
        run_check("R1 unconfigured R6", 0, 1, 0);

        configure(1'b1, 32'h20, 32'h30, 16'h20);
        run_check("R2 port0 len1", 0, 1, 0);
        run_check("R10 port0 len4", 0, 4, 2);
        run_check("R8 port8 denied", 8, 1, 1);
        run_check("R8 port9 allowed", 9, 1, 0);
        run_check("R8 port18 denied", 18, 1, 3);
        run_check("R8 port17 allowed", 17, 1, 0);
        run_check("R8 cross port6 len2", 6, 2, 1);
        run_check("R8 cross port7 len2", 7, 2, 0);
        run_check("R5 edge port123 len4", 123, 4, 2);
        run_check("R5 port124 len4", 124, 4, 0);
        run_check("R5 port126 len2", 126, 2, 0);
        run_check("R10 port120 len4", 120, 4, 4);

        configure(1'b0, 32'h20, 32'h30, 16'h20);
        run_check("R3 16bit R6", 0, 1, 0);
        configure(1'b1, 32'h20, 32'h30, 16'h0);
        run_check("R3 mapbase0 R6", 0, 1, 0);
        configure(1'b1, 32'h20, 32'h30, 16'h30);
        run_check("R3 mapbase eq limit R6", 0, 1, 0);

        configure(1'b1, 32'h20, 32'h10030, 16'h20);
        run_check("R4 trunc port123", 123, 4, 1);
        run_check("R4 trunc port124", 124, 4, 0);
        run_check("R4 trunc port8", 8, 1, 0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule